// File: doc/BRIEF.md
# Dual-Mode Lookup-Table Transmit Equalizer

This block sits on the slow parallel side of a serial transmitter, just before the serializer. On every clock it takes a word of eight symbol slots. For each slot it forms a short window from that symbol and its predecessors, uses the window as an address into a small table, and outputs the 6-bit amplitude code stored there. The segmented output driver then turns that code into a voltage. Because the table holds the shaped levels, feed-forward equalization needs no arithmetic at line rate.

One input picks the signalling mode. In binary mode the window spans four one-bit symbols. In four-level mode it spans two Gray-coded two-bit symbols. Both windows give a 4-bit address, so the same 16-entry table shape serves either mode, with one bank per mode. Symbols at the end of each word are kept so that windows which cross a word edge see the true earlier symbols. A simple write port fills a bank while that bank's mode is not active.

Top module: `lutfe_equalizer`

## Requirements
- R1: `dout` is a register. Codes for the word on `din` in a cycle appear after the next rising edge and not before. A synchronous reset (`rst_n` low at an edge) clears `dout` to zero and clears the symbol history to zero.
- R2: Slot i is `din[2i+1:2i]`, and its code is `dout[6i+5:6i]`. Slot 0 goes out first, and slot 7 of one word comes just before slot 0 of the next.
- R3: With `mode` = 0 (binary), only bit 0 of each slot counts, and bit 1 has no effect. The address for slot i is {b(i-3), b(i-2), b(i-1), b(i)}, with the current bit b(i) in the LSB.
- R4: With `mode` = 1 (four-level), each symbol maps to a level: 00→0, 01→1, 11→2, 10→3. The address for slot i is {L(i-1), L(i)}, with the current level in bits 1:0.
- R5: A window that reaches before slot 0 uses the symbols of slots 5, 6 and 7 of the previous word, in that order of age.
- R6: Bank 0 serves binary mode and bank 1 serves four-level mode. A write with `wr_en` high stores `wr_data` at `wr_addr` of bank `wr_bank` at the rising edge. The write changes lookups from the following cycle on.
- R7: A write whose `wr_bank` equals the current `mode` is ignored.
- R8: After reset, bank 0 entry e holds 63 if bit 0 of e is set and 0 otherwise. Bank 1 entry e holds 21 × e[1:0].
- R9: A change of `mode` applies to the word presented in the same cycle, with no extra latency. The history carries across the change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Parallel-domain clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode | input | 1 | 0 = binary 4-tap, 1 = four-level 2-tap |
| din | input | 16 | Eight 2-bit symbol slots |
| wr_en | input | 1 | Table write strobe |
| wr_bank | input | 1 | Bank to write |
| wr_addr | input | 4 | Table entry to write |
| wr_data | input | 6 | Code to store |
| dout | output | 48 | Eight 6-bit amplitude codes |

## Verification
The history register is the only state that crosses a word boundary. If it is wrong, only slots 0 to 2 of the next word show it, one edge after the word that fed it. If it is wrong in four-level mode, only slot 0 shows it. A fault in a table cell shows only when some window addresses that cell, so the tests sweep windows across every address. A bad write gate shows as a changed code in the active mode one cycle after an ignored write.

// File: rtl/lutfe_pkg.sv
// Shared types and constants for the lookup-table equalizer.
// Assumes a fixed 4-bit table address in both modes.
package lutfe_pkg;
    typedef enum logic {
        MODE_NRZ  = 1'b0,
        MODE_PAM4 = 1'b1
    } line_mode_e;

    localparam int unsigned IDX_W     = 4;
    localparam int unsigned ENTRIES   = 1 << IDX_W;
    localparam int unsigned NRZ_TAPS  = 4;
    localparam int unsigned HIST_SYMS = NRZ_TAPS - 1;

    // Gray symbol to level number.
    function automatic logic [1:0] gray_level(input logic [1:0] sym);
        return {sym[1], sym[1] ^ sym[0]};
    endfunction
endpackage

// File: rtl/lutfe_bank.sv
// One table bank: ENTRIES cells of CODE_W bits, one write port and
// SLOTS read ports. Resets to the plain-level codes of its mode.
// Assumes the caller gates writes.
module lutfe_bank
    import lutfe_pkg::*;
#(
    parameter int unsigned SLOTS       = 8,
    parameter int unsigned CODE_W      = 6,
    parameter bit          PAM_DEFAULT = 1'b0
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      we,
    input  logic [IDX_W-1:0]          waddr,
    input  logic [CODE_W-1:0]         wdata,
    input  logic [SLOTS*IDX_W-1:0]    raddr,
    output logic [SLOTS*CODE_W-1:0]   rdata
);
    localparam int unsigned MAXC = (1 << CODE_W) - 1;

    // Unequalized code for an entry.
    function automatic logic [CODE_W-1:0] plain_code(input int unsigned e);
        int unsigned v;
        if (PAM_DEFAULT) v = (e % 4) * (MAXC / 3);
        else             v = (e % 2) * MAXC;
        return v[CODE_W-1:0];
    endfunction

    logic [CODE_W-1:0] cells [ENTRIES];

    for (genvar e = 0; e < ENTRIES; e++) begin : g_cell
        logic [CODE_W-1:0] cell_q;
        // Hold one table entry; load default on reset.
        always_ff @(posedge clk) begin
            if (!rst_n)
                cell_q <= plain_code(e);
            else if (we && waddr == IDX_W'(e))
                cell_q <= wdata;
        end
        assign cells[e] = cell_q;
    end

    for (genvar s = 0; s < SLOTS; s++) begin : g_read
        assign rdata[s*CODE_W +: CODE_W] = cells[raddr[s*IDX_W +: IDX_W]];
    end
endmodule

// File: rtl/lutfe_window.sv
// Builds the per-slot table address from the current word and the
// kept history. Binary: four bits, newest in LSB. Four-level: two
// Gray-decoded levels, newest in bits 1:0. Purely combinational.
module lutfe_window
    import lutfe_pkg::*;
#(
    parameter int unsigned SLOTS = 8
) (
    input  line_mode_e                mode,
    input  logic [2*SLOTS-1:0]        din,
    input  logic [HIST_SYMS-1:0]      hist_bits,
    input  logic [1:0]                hist_sym,
    output logic [SLOTS*IDX_W-1:0]    idx
);
    // Bit stream oldest-first: history then bit 0 of each slot.
    logic [SLOTS+HIST_SYMS-1:0] bstream;
    assign bstream[HIST_SYMS-1:0] = hist_bits;

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        logic [1:0]       prev_sym;
        logic [IDX_W-1:0] nrz_idx;
        logic [IDX_W-1:0] pam_idx;

        assign bstream[HIST_SYMS + s] = din[2*s];

        if (s == 0) begin : g_first
            assign prev_sym = hist_sym;
        end else begin : g_rest
            assign prev_sym = din[2*(s-1) +: 2];
        end

        assign nrz_idx = {bstream[s], bstream[s+1], bstream[s+2], bstream[s+3]};
        assign pam_idx = {gray_level(prev_sym), gray_level(din[2*s +: 2])};
        assign idx[s*IDX_W +: IDX_W] = (mode == MODE_PAM4) ? pam_idx : nrz_idx;
    end
endmodule

// File: rtl/lutfe_equalizer.sv
// Dual-mode lookup-table equalizer. Per word: form windows, look up
// the active bank, register the codes (one cycle latency). Keeps the
// tail of each word for the next. Writes to the active bank are dropped.
// Assumes SLOTS >= HIST_SYMS.
module lutfe_equalizer
    import lutfe_pkg::*;
#(
    parameter int unsigned SLOTS  = 8,
    parameter int unsigned CODE_W = 6
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     mode,
    input  logic [2*SLOTS-1:0]       din,
    input  logic                     wr_en,
    input  logic                     wr_bank,
    input  logic [IDX_W-1:0]         wr_addr,
    input  logic [CODE_W-1:0]        wr_data,
    output logic [SLOTS*CODE_W-1:0]  dout
);
    localparam int unsigned OUT_W = SLOTS * CODE_W;

    line_mode_e              mode_e;
    logic [HIST_SYMS-1:0]    hist_bits_q;
    logic [1:0]              hist_sym_q;
    logic [SLOTS*IDX_W-1:0]  idx;
    logic [OUT_W-1:0]        bank_rd [2];
    logic [OUT_W-1:0]        dout_q;

    assign mode_e = line_mode_e'(mode);

    lutfe_window #(.SLOTS(SLOTS)) u_window (
        .mode      (mode_e),
        .din       (din),
        .hist_bits (hist_bits_q),
        .hist_sym  (hist_sym_q),
        .idx       (idx)
    );

    for (genvar b = 0; b < 2; b++) begin : g_bank
        logic bank_we;
        assign bank_we = wr_en && (wr_bank == 1'(b)) && (mode != 1'(b));
        lutfe_bank #(
            .SLOTS       (SLOTS),
            .CODE_W      (CODE_W),
            .PAM_DEFAULT (b == 1)
        ) u_bank (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (bank_we),
            .waddr (wr_addr),
            .wdata (wr_data),
            .raddr (idx),
            .rdata (bank_rd[b])
        );
    end

    // Keep the last symbols of the word for the next word's windows.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist_bits_q <= '0;
            hist_sym_q  <= '0;
        end else begin
            for (int h = 0; h < HIST_SYMS; h++)
                hist_bits_q[h] <= din[2*(SLOTS-HIST_SYMS+h)];
            hist_sym_q <= din[2*SLOTS-1 -: 2];
        end
    end

    // Register the codes of the active bank.
    always_ff @(posedge clk) begin
        if (!rst_n)
            dout_q <= '0;
        else
            dout_q <= (mode_e == MODE_PAM4) ? bank_rd[1] : bank_rd[0];
    end

    assign dout = dout_q;
endmodule

// File: rtl/lutfe_equalizer_chk.sv
// Property checker for lutfe_equalizer, attached by bind.
module lutfe_equalizer_chk #(
    parameter int unsigned SLOTS  = 8,
    parameter int unsigned CODE_W = 6
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     mode,
    input logic [2*SLOTS-1:0]       din,
    input logic                     wr_en,
    input logic [SLOTS*CODE_W-1:0]  dout
);
    localparam int unsigned MAXC = (1 << CODE_W) - 1;

    // Level number of a Gray symbol, by lookup.
    function automatic int unsigned lvl(input logic [1:0] s);
        case (s)
            2'b00:   return 0;
            2'b01:   return 1;
            2'b11:   return 2;
            default: return 3;
        endcase
    endfunction

    logic              pristine;
    logic [1:0]        calm;
    logic [2*SLOTS-1:0] din_d;
    logic              mode_d;

    // Track whether any write was attempted since reset.
    always_ff @(posedge clk) begin
        if (!rst_n)     pristine <= 1'b1;
        else if (wr_en) pristine <= 1'b0;
    end

    // Previous-cycle copies of the inputs.
    always_ff @(posedge clk) begin
        din_d  <= din;
        mode_d <= mode;
    end

    // Count consecutive cycles with unchanged data and mode.
    always_ff @(posedge clk) begin
        if (!rst_n)
            calm <= '0;
        else if (din == din_d && mode == mode_d)
            calm <= (calm == 2'd3) ? calm : calm + 2'd1;
        else
            calm <= '0;
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> dout == '0);

    // R7
    held_input_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (calm >= 2'd2 && din == din_d && mode == mode_d) |=> $stable(dout));

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        // R8
        nrz_default_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (pristine && !mode) |=>
                dout[s*CODE_W +: CODE_W] == ($past(din[2*s]) ? CODE_W'(MAXC) : '0));

        // R8
        pam_default_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (pristine && mode) |=>
                dout[s*CODE_W +: CODE_W] == CODE_W'(lvl($past(din[2*s +: 2])) * (MAXC / 3)));
    end
endmodule

bind lutfe_equalizer lutfe_equalizer_chk #(.SLOTS(SLOTS), .CODE_W(CODE_W)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .mode  (mode),
    .din   (din),
    .wr_en (wr_en),
    .dout  (dout)
);

// File: tb/sim_lutfe_equalizer.sv
// Directed bench for lutfe_equalizer with its own reference model.
module sim_lutfe_equalizer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode = 1'b0;
    logic [15:0] din = '0;
    logic        wr_en = 1'b0;
    logic        wr_bank = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [5:0]  wr_data = '0;
    logic [47:0] dout;

    int checks = 0;
    int errors = 0;

    int          tab [2][16];
    logic [2:0]  mh_bits;     // bit 0 of slots 5,6,7 of last word; [0] oldest
    logic [1:0]  mh_sym;      // slot 7 of last word
    logic [47:0] pend_exp;
    logic [31:0] rs = 32'h2545_F491;

    always #5 clk = ~clk;

    lutfe_equalizer u0 (
        .clk(clk), .rst_n(rst_n), .mode(mode), .din(din),
        .wr_en(wr_en), .wr_bank(wr_bank), .wr_addr(wr_addr),
        .wr_data(wr_data), .dout(dout)
    );

    function automatic logic [31:0] rnd();
        rs = rs ^ (rs << 13);
        rs = rs ^ (rs >> 17);
        rs = rs ^ (rs << 5);
        return rs;
    endfunction

    function automatic int glvl(input logic [1:0] s);
        case (s)
            2'b00: return 0;
            2'b01: return 1;
            2'b11: return 2;
            default: return 3;
        endcase
    endfunction

    function automatic void model_reset();
        for (int e = 0; e < 16; e++) begin
            tab[0][e] = (e % 2) * 63;
            tab[1][e] = (e % 4) * 21;
        end
        mh_bits = '0;
        mh_sym  = '0;
    endfunction

    // Expected codes for word d in mode m from the current model state.
    function automatic logic [47:0] model(input logic [15:0] d, input logic m);
        logic [47:0] r;
        logic [10:0] bs;
        logic [1:0]  prev;
        int          a;
        bs[2:0] = mh_bits;
        for (int i = 0; i < 8; i++) bs[3+i] = d[2*i];
        for (int i = 0; i < 8; i++) begin
            if (m == 1'b0) begin
                a = bs[i]*8 + bs[i+1]*4 + bs[i+2]*2 + bs[i+3];
            end else begin
                prev = (i == 0) ? mh_sym : d[2*(i-1) +: 2];
                a = glvl(prev)*4 + glvl(d[2*i +: 2]);
            end
            r[6*i +: 6] = 6'(tab[m][a]);
        end
        return r;
    endfunction

    task automatic check(input string tag, input logic [47:0] act, input logic [47:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive one cycle's inputs at the falling edge and advance the model.
    task automatic drive(input logic [15:0] d, input logic m, input logic we,
                         input logic wb, input logic [3:0] wa, input logic [5:0] wd);
        @(negedge clk);
        din = d; mode = m; wr_en = we; wr_bank = wb; wr_addr = wa; wr_data = wd;
        pend_exp = model(d, m);
        for (int h = 0; h < 3; h++) mh_bits[h] = d[2*(5+h)];
        mh_sym = d[15:14];
        if (we && wb != m) tab[wb][wa] = int'(wd);
    endtask

    task automatic settle(input bit chk, input string tag);
        @(posedge clk);
        #1;
        if (chk) check(tag, dout, pend_exp);
    endtask

    task automatic step(input logic [15:0] d, input logic m, input string tag);
        drive(d, m, 1'b0, 1'b0, 4'd0, 6'd0);
        settle(1'b1, tag);
    endtask

    task automatic wr(input logic m, input logic wb, input logic [3:0] wa, input logic [5:0] wd);
        drive(16'h0000, m, 1'b1, wb, wa, wd);
        settle(1'b0, "");
    endtask

    task automatic t_reset();
        @(negedge clk);
        rst_n = 1'b0; wr_en = 1'b0; din = 16'hFFFF;
        @(posedge clk);
        @(posedge clk);
        model_reset();
        @(negedge clk);
        check("R1 reset clears output", dout, '0);
        rst_n = 1'b1;
    endtask

    task automatic t_nrz_default();
        step(16'h5555, 1'b0, "R8 binary default all ones");
        step(16'hAAAA, 1'b0, "R3 binary bit1 ignored");
        step(16'h0001, 1'b0, "R2 binary slot0 only");
        step(16'h4000, 1'b0, "R2 binary slot7 only");
        for (int k = 0; k < 6; k++) step(16'(rnd()), 1'b0, "R8 binary default random");
    endtask

    task automatic t_pam_default();
        step(16'hE4E4, 1'b1, "R4 four-level default levels");
        step(16'h1B1B, 1'b1, "R4 four-level default reversed");
        for (int k = 0; k < 6; k++) step(16'(rnd()), 1'b1, "R8 four-level default random");
    endtask

    task automatic t_latency();
        logic [47:0] first;
        step(16'h0015, 1'b0, "R1 latency first word");
        first = pend_exp;
        drive(16'h5400, 1'b0, 1'b0, 1'b0, 4'd0, 6'd0);
        #2;
        check("R1 output holds before edge", dout, first);
        settle(1'b1, "R1 latency second word");
    endtask

    task automatic t_load_nrz();
        for (int e = 0; e < 16; e++) wr(1'b1, 1'b0, 4'(e), 6'((e*5 + 3) % 64));
        step(16'h5400, 1'b0, "R5 binary history set");
        step(16'h0000, 1'b0, "R5 binary history into slots 0-2");
        step(16'h1000, 1'b0, "R5 binary history single bit");
        step(16'h0000, 1'b0, "R5 binary history oldest");
        step(16'h0111, 1'b0, "R3 binary window order");
        step(16'h0111 ^ 16'hAAAA, 1'b0, "R3 binary bit1 ignored loaded");
        for (int k = 0; k < 10; k++) step(16'(rnd()), 1'b0, "R6 binary loaded random");
    endtask

    task automatic t_load_pam();
        for (int e = 0; e < 16; e++) wr(1'b0, 1'b1, 4'(e), 6'(63 - 3*e));
        step(16'h8000, 1'b1, "R5 four-level history set");
        step(16'h0000, 1'b1, "R5 four-level history into slot0");
        step(16'h4E1B, 1'b1, "R4 four-level gray order");
        for (int k = 0; k < 10; k++) step(16'(rnd()), 1'b1, "R6 four-level loaded random");
    endtask

    task automatic t_active_ignored();
        for (int e = 0; e < 16; e++) wr(1'b0, 1'b0, 4'(e), 6'd0);
        for (int k = 0; k < 6; k++) step(16'(rnd()), 1'b0, "R7 binary write while active ignored");
        for (int e = 0; e < 16; e++) wr(1'b1, 1'b1, 4'(e), 6'd7);
        for (int k = 0; k < 6; k++) step(16'(rnd()), 1'b1, "R7 four-level write while active ignored");
    endtask

    task automatic t_mode_switch();
        for (int k = 0; k < 12; k++) step(16'(rnd()), 1'(k % 2), "R9 mode switch per word");
        step(16'hC3C3, 1'b0, "R9 switch to binary");
        step(16'hC3C3, 1'b1, "R9 switch to four-level");
    endtask

    initial begin
        #1_000_000;
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        model_reset();
        t_reset();
        t_nrz_default();
        t_pam_default();
        t_latency();
        t_load_nrz();
        t_load_pam();
        t_active_ignored();
        t_mode_switch();
        t_reset();
        step(16'h9C36, 1'b1, "R8 defaults restored after reset");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule